// File: doc/BRIEF.md
# Announced-Transfer Fetch Sequencer

This block produces the fetch address for a processor with two stages, fetch and execute, in which every transfer of control is announced one instruction ahead. The instruction that comes before a transfer writes a 3-bit status value. That value gives the kind of the coming transfer and names the internal register that already holds its destination: the computed-target register or the saved-sequential register. No target buffer exists. The destination is always read from one of those two registers. Direction is guessed by a table of 2-bit saturating counters, and the table is consulted only in the cycle in which the announced conditional instruction is being fetched.

The block runs as a small state machine over the execute slot. ST_EMPTY means the slot holds nothing valid, which is the case after reset or after a flush. ST_EMPTY_ARMED means the slot is empty but an announcement is waiting for the instruction now being fetched. ST_RUN means an ordinary instruction is executing. ST_COND means an announced conditional transfer is executing and is being resolved. ST_JUMP means an announced unconditional transfer is executing.

The transitions are as follows. EMPTY goes to RUN. EMPTY_ARMED goes to COND or JUMP, depending on the held announcement. From RUN, COND or JUMP the machine goes to COND or JUMP when a transfer is announced, and to RUN otherwise. COND goes to EMPTY when a misprediction is resolved, or to EMPTY_ARMED if the executing instruction also made an announcement in that cycle.

Top module: `ptb_fetch_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_pc` equals `RESET_PC`, `flush` and `bp_lookup` are low, and every counter holds 1 (weakly not taken).
- R2: If no transfer is in effect, the next fetch address is the current one plus 1. Addresses count instructions.
- R3: Status encoding: bits [2:1] = 01 is conditional, 10 is unconditional, 00 and 11 are no transfer. Bit 0 selects the source: 0 is `targ_in`, 1 is `seq_in`.
- R4: For an announced unconditional transfer, the next fetch address is the selected register. There is no lookup, no flush and no counter change.
- R5: `bp_lookup` is high only in a cycle in which a conditional transfer is in effect for the instruction being fetched.
- R6: The counter used is indexed by `fetch_pc[IDX_W-1:0]` of the announced instruction. A value of 2 or 3 sends the next fetch to the selected register; a value of 0 or 1 sends it to `fetch_pc`+1.
- R7: When the conditional instruction executes, its counter is incremented if `cmp_taken` is high and decremented if it is low, saturating at 0 and 3. A lookup in the same cycle sees the value before the update.
- R8: If `cmp_taken` differs from the prediction, `flush` is high for that one cycle. The next fetch is the latched target if the branch is taken, or the branch address plus 1 if it is not.
- R9: An announcement covers only the next instruction. After that instruction executes, the one after it is treated as no transfer unless it is newly announced.
- R10: In an empty-slot cycle (the first cycle after reset, or the cycle after a flush), `ptb_wr`, `ptb_val` and `cmp_taken` have no effect.
- R11: An announcement written in a flush cycle applies to the corrected instruction. Its lookup and redirect take place in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptb_wr | input | 1 | The executing instruction writes the status value |
| ptb_val | input | 3 | Status value: transfer kind and target source |
| cmp_taken | input | 1 | Resolved direction of the executing instruction |
| targ_in | input | AW | Computed-target register |
| seq_in | input | AW | Saved-sequential register |
| fetch_pc | output | AW | Address being fetched this cycle |
| flush | output | 1 | Discard the instruction fetched this cycle |
| bp_lookup | output | 1 | The counter table is read this cycle |

## Verification
The bench goes after a misprediction resolved in the same cycle as a new announcement. A design that drops that announcement, or applies it to the squashed instruction, fetches the wrong address one cycle later. It also checks that the empty slot after a flush ignores a stale compare result and status write; a design that does not would flush twice or redirect spuriously. Counter saturation and reads of an index in the same cycle as its update are exercised by small, reused target addresses. Reserved status codes are checked so that a design treating them as jumps leaves the sequential path.

// File: rtl/ptb_fetch_pkg.sv
package ptb_fetch_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_EMPTY_ARMED,
        ST_RUN,
        ST_COND,
        ST_JUMP
    } fc_state_e;

    typedef enum logic [1:0] {
        XK_NONE = 2'b00,
        XK_COND = 2'b01,
        XK_JUMP = 2'b10,
        XK_RSVD = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       use_seq;
    } xfer_stat_t;

    localparam xfer_stat_t NO_XFER = '{kind: XK_NONE, use_seq: 1'b0};

    function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
        if (up)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/ptb_bimodal.sv
module ptb_bimodal
    import ptb_fetch_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] ctr_w [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ctr
        logic [1:0] c_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                c_q <= 2'b01;
            else if (wr_en && wr_idx == IDX_W'(e))
                c_q <= sat_step(c_q, wr_taken);
        end
        assign ctr_w[e] = c_q;
    end

    assign rd_taken = ctr_w[rd_idx][1];

endmodule

// File: rtl/ptb_ctrl_fsm.sv
module ptb_ctrl_fsm
    import ptb_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptb_wr,
    input  logic [2:0] ptb_val,
    input  logic       mispredict,
    output fc_state_e  state,
    output xfer_stat_t eff,
    output logic       slot_valid
);
    fc_state_e  st_q, st_d;
    xfer_stat_t arm_q, arm_d;
    xfer_stat_t wr_stat;

    assign wr_stat = ptb_wr ? xfer_stat_t'(ptb_val) : NO_XFER;

    function automatic fc_state_e after_ann(input xfer_kind_e k);
        unique case (k)
            XK_COND: return ST_COND;
            XK_JUMP: return ST_JUMP;
            default: return ST_RUN;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_EMPTY;
            arm_q <= NO_XFER;
        end else begin
            st_q  <= st_d;
            arm_q <= arm_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        arm_d = arm_q;
        unique case (st_q)
            ST_EMPTY:       st_d = ST_RUN;
            ST_EMPTY_ARMED: st_d = after_ann(arm_q.kind);
            ST_RUN, ST_JUMP: st_d = after_ann(wr_stat.kind);
            ST_COND: begin
                if (mispredict) begin
                    if (wr_stat.kind == XK_COND || wr_stat.kind == XK_JUMP) begin
                        st_d  = ST_EMPTY_ARMED;
                        arm_d = wr_stat;
                    end else begin
                        st_d = ST_EMPTY;
                    end
                end else begin
                    st_d = after_ann(wr_stat.kind);
                end
            end
            default:        st_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        eff        = NO_XFER;
        slot_valid = 1'b0;
        unique case (st_q)
            ST_EMPTY:        eff = NO_XFER;
            ST_EMPTY_ARMED:  eff = arm_q;
            ST_RUN, ST_JUMP: begin
                slot_valid = 1'b1;
                eff        = wr_stat;
            end
            ST_COND: begin
                slot_valid = 1'b1;
                eff        = mispredict ? NO_XFER : wr_stat;
            end
            default:         eff = NO_XFER;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/ptb_fetch_top.sv
module ptb_fetch_top
    import ptb_fetch_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            IDX_W    = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptb_wr,
    input  logic [2:0]    ptb_val,
    input  logic          cmp_taken,
    input  logic [AW-1:0] targ_in,
    input  logic [AW-1:0] seq_in,
    output logic [AW-1:0] fetch_pc,
    output logic          flush,
    output logic          bp_lookup
);
    fc_state_e     state;
    xfer_stat_t    eff;
    logic          slot_valid;
    logic [1:0]    eff_kind;
    logic          mispredict;
    logic          bp_taken;
    logic [AW-1:0] pc_q, pc_d, sel_tgt;
    logic          pred_q;
    logic [AW-1:0] bpc_q, tgt_q;

    ptb_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptb_wr     (ptb_wr),
        .ptb_val    (ptb_val),
        .mispredict (mispredict),
        .state      (state),
        .eff        (eff),
        .slot_valid (slot_valid)
    );

    ptb_bimodal #(.IDX_W(IDX_W)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pc_q[IDX_W-1:0]),
        .rd_taken (bp_taken),
        .wr_en    (state == ST_COND),
        .wr_idx   (bpc_q[IDX_W-1:0]),
        .wr_taken (cmp_taken)
    );

    assign eff_kind   = eff.kind;
    assign mispredict = (state == ST_COND) && (cmp_taken != pred_q);
    assign sel_tgt    = eff.use_seq ? seq_in : targ_in;

    always_comb begin
        if (mispredict)
            pc_d = cmp_taken ? tgt_q : bpc_q + AW'(1);
        else if (eff.kind == XK_JUMP)
            pc_d = sel_tgt;
        else if (eff.kind == XK_COND && bp_taken)
            pc_d = sel_tgt;
        else
            pc_d = pc_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            pred_q <= 1'b0;
            bpc_q  <= '0;
            tgt_q  <= '0;
        end else begin
            pc_q <= pc_d;
            if (eff.kind == XK_COND) begin
                pred_q <= bp_taken;
                bpc_q  <= pc_q;
                tgt_q  <= sel_tgt;
            end
        end
    end

    assign fetch_pc  = pc_q;
    assign flush     = mispredict;
    assign bp_lookup = (eff.kind == XK_COND);

endmodule

// File: rtl/ptb_fetch_chk.sv
module ptb_fetch_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ptb_wr,
    input logic [2:0]    ptb_val,
    input logic [AW-1:0] targ_in,
    input logic [AW-1:0] seq_in,
    input logic [AW-1:0] fetch_pc,
    input logic          flush,
    input logic          bp_lookup,
    input logic          slot_valid
);
    logic ann_xfer;
    assign ann_xfer = ptb_wr && (ptb_val[2:1] == 2'b01 || ptb_val[2:1] == 2'b10);

    a_r8_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    a_r11_defer_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !bp_lookup);

    a_r5_lookup_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_lookup && slot_valid) |-> (ptb_wr && ptb_val[2:1] == 2'b01));

    a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid |-> !flush);

    a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !flush && ptb_wr && ptb_val[2:1] == 2'b10)
        |=> fetch_pc == $past(ptb_val[0] ? seq_in : targ_in));

    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !flush && !ann_xfer) |=> fetch_pc == $past(fetch_pc) + AW'(1));

endmodule

bind ptb_fetch_top ptb_fetch_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptb_wr     (ptb_wr),
    .ptb_val    (ptb_val),
    .targ_in    (targ_in),
    .seq_in     (seq_in),
    .fetch_pc   (fetch_pc),
    .flush      (flush),
    .bp_lookup  (bp_lookup),
    .slot_valid (slot_valid)
);

// File: tb/ptb_fetch_top_tb_top.sv
module ptb_fetch_top_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptb_wr = 1'b0;
    logic [2:0]    ptb_val = 3'b000;
    logic          cmp_taken = 1'b0;
    logic [AW-1:0] targ_in = '0;
    logic [AW-1:0] seq_in = '0;
    logic [AW-1:0] fetch_pc;
    logic          flush;
    logic          bp_lookup;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ptb_fetch_top #(.AW(AW), .IDX_W(8), .RESET_PC('0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ptb_wr(ptb_wr), .ptb_val(ptb_val),
        .cmp_taken(cmp_taken), .targ_in(targ_in), .seq_in(seq_in),
        .fetch_pc(fetch_pc), .flush(flush), .bp_lookup(bp_lookup)
    );

    // reference model: 0 empty, 1 empty armed, 2 run, 3 cond, 4 jump
    int            ms;
    logic [AW-1:0] m_pc, m_bpc, m_tgt;
    logic          m_pred;
    logic [2:0]    m_arm;
    int            m_ctr [256];

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int next_of(input logic [1:0] k);
        if (k == 2'b01) return 3;
        if (k == 2'b10) return 4;
        return 2;
    endfunction

    task automatic step(input logic wr, input logic [2:0] v, input logic cmp,
                        input logic [AW-1:0] t, input logic [AW-1:0] s);
        logic          mis, pr, usq;
        logic [1:0]    ek;
        logic [AW-1:0] tg, npc;
        string         tag;
        ptb_wr = wr; ptb_val = v; cmp_taken = cmp; targ_in = t; seq_in = s;
        #1;
        mis = (ms == 3) && (cmp != m_pred);
        if (ms == 0) begin ek = 2'b00; usq = 1'b0; end
        else if (ms == 1) begin ek = m_arm[2:1]; usq = m_arm[0]; end
        else if (mis || !wr) begin ek = 2'b00; usq = 1'b0; end
        else begin ek = v[2:1]; usq = v[0]; end
        tg = usq ? s : t;
        pr = (m_ctr[m_pc[7:0]] >= 2);
        if (mis) tag = "R8";
        else if (ms == 1) tag = "R11";
        else if (ms == 0) tag = "R10";
        else if (ek == 2'b10) tag = "R4";
        else if (ek == 2'b01) tag = "R6,R7";
        else if (wr && v[2:1] == 2'b11) tag = "R3";
        else if (ms == 3 || ms == 4) tag = "R9";
        else tag = "R2";
        check({tag, " fetch_pc"}, fetch_pc, m_pc);
        check("R8 flush", AW'(flush), AW'(mis));
        check("R5 bp_lookup", AW'(bp_lookup), AW'(ek == 2'b01));
        // advance model
        if (mis) npc = cmp ? m_tgt : m_bpc + 1;
        else if (ek == 2'b10) npc = tg;
        else if (ek == 2'b01 && pr) npc = tg;
        else npc = m_pc + 1;
        if (ms == 3) begin
            if (cmp) m_ctr[m_bpc[7:0]] = (m_ctr[m_bpc[7:0]] == 3) ? 3 : m_ctr[m_bpc[7:0]] + 1;
            else     m_ctr[m_bpc[7:0]] = (m_ctr[m_bpc[7:0]] == 0) ? 0 : m_ctr[m_bpc[7:0]] - 1;
        end
        if (ek == 2'b01) begin m_pred = pr; m_bpc = m_pc; m_tgt = tg; end
        if (ms == 0) ms = 2;
        else if (ms == 1) ms = next_of(m_arm[2:1]);
        else if (mis) begin
            if (wr && (v[2:1] == 2'b01 || v[2:1] == 2'b10)) begin ms = 1; m_arm = v; end
            else ms = 0;
        end else ms = next_of(ek);
        m_pc = npc;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        ms = 0; m_pc = '0; m_bpc = '0; m_tgt = '0; m_pred = 1'b0; m_arm = 3'b000;
        for (int i = 0; i < 256; i++) m_ctr[i] = 1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset fetch_pc", fetch_pc, '0);
        check("R1 reset flush", AW'(flush), '0);
        check("R1 reset bp_lookup", AW'(bp_lookup), '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: empty slot ignores a jump and a compare
        step(1'b1, 3'b100, 1'b1, 32'd40, 32'd50);
        step(1'b0, 3'b000, 1'b0, 32'd0, 32'd0);           // R2
        step(1'b1, 3'b100, 1'b0, 32'd20, 32'd30);         // R4 TARG
        step(1'b1, 3'b101, 1'b0, 32'd20, 32'd30);         // R4 SEQ
        step(1'b1, 3'b110, 1'b0, 32'd5, 32'd6);           // R3 reserved
        step(1'b1, 3'b010, 1'b0, 32'd10, 32'd11);         // R6 predicts not taken
        step(1'b1, 3'b011, 1'b1, 32'd12, 32'd14);         // R8 mispredict + R11 announcement
        step(1'b1, 3'b100, 1'b1, 32'd60, 32'd61);         // R10 empty armed ignores inputs
        step(1'b0, 3'b000, 1'b0, 32'd0, 32'd0);           // R11 resolve deferred
        step(1'b0, 3'b000, 1'b0, 32'd0, 32'd0);           // R9
        step(1'b0, 3'b000, 1'b0, 32'd0, 32'd0);
        for (int n = 0; n < 6000; n++) begin
            logic       w;
            logic [2:0] v;
            w = ($urandom % 3) == 0;
            v = 3'($urandom);
            step(w, v, ($urandom % 4) != 0, AW'($urandom % 48), AW'($urandom % 48));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule